// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is a watchdog timer behind a single 16-bit control address. Software may not change its setting with one ordinary store: a new setting is taken only as the third write of a keyed sequence. That sequence opens with the word 0x3333, continues with 0xCCCC, and the write after those two becomes the new control value. A second, shorter sequence restarts the count and leaves the setting alone: 0xAAAA followed by 0x5555. Plain writes outside these sequences have no effect on the setting.

The control word holds an enable pair and a timeout field. When bits 15 and 14 are both set, the watchdog is active and counts clock cycles. Bits 7 down to 1 form a one-hot timeout field, and bit k selects a period of 2^(BASE+k) cycles, where BASE is a parameter with a default of 23. When the period runs out, the block drives its reset output high for a fixed number of cycles, reloads its counter and keeps running. While the watchdog is active, a keyed write may only disable it. A new period is therefore set in two steps: first a keyed write of a disabling value such as 0 or 0x4080, then a keyed write of the new value.

Top module: `keyed_watchdog`

## Requirements
- R1: A write loads the control register only when it directly follows a write of 0x3333 and then a write of 0xCCCC. Any other write leaves the register unchanged. A keyed load also clears the counter.
- R2: A write that breaks a sequence sends the key checker back to idle, and that same word is then evaluated as the possible first word of a new sequence. For example, 0x3333, 0xAAAA, 0x5555 performs a restart, and 0x3333, 0x3333, 0xCCCC, v loads v.
- R3: A write of 0xAAAA immediately followed by a write of 0x5555 clears the counter without changing the control register.
- R4: While bits 15 and 14 of the control register are both set, a keyed value that also has both bits set is ignored. A keyed value that clears either bit (for example 0x0000 or 0x4080) is loaded and disables the watchdog.
- R5: Bits 7 down to 1 form the timeout field. With only bit k set, the reset output rises exactly 2^(TO_BASE_LOG2+k) cycles after the clock edge of the load or restart. A field that is not one-hot stops the counter.
- R6: Unless bits 15 and 14 are both set, the counter does not advance and no new reset pulse starts.
- R7: On expiry the reset output is high for exactly PULSE_LEN cycles (16 by default). The counter reloads at expiry, so the next expiry comes one full period after the first.
- R8: A read strobe presents the control register on rd_data in the next cycle. Reads never change the state of a key sequence.
- R9: After reset the control register holds RST_CFG (0x0000), the key checker is idle, and the reset output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control address |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe for the control address |
| rd_data | output | 16 | Control register, registered on a read strobe |
| wd_rst_o | output | 1 | Reset request, high for PULSE_LEN cycles on expiry |

## Verification
A key checker stuck in the wrong state shows up one write later. A load that should have been taken (or refused) becomes visible on the next read-back, and a restart that is lost or spurious moves the rise of wd_rst_o by many cycles. A counter error, such as a wrong terminal bit, a missed clear or a missed reload, moves the edge of the reset pulse away from the exact cycle the bench expects. An error in the stretcher changes the pulse width by at least one cycle. Because the bench compares wd_rst_o in every cycle of each window it schedules, it reports these faults at the first cycle where the output differs.

// File: rtl/keyed_watchdog_pkg.sv
package keyed_watchdog_pkg;

   localparam int unsigned WORD_W = 16;

   localparam logic [WORD_W-1:0] KEY_CFG_OPEN  = 16'h3333;
   localparam logic [WORD_W-1:0] KEY_CFG_ARM   = 16'hCCCC;
   localparam logic [WORD_W-1:0] KEY_KICK_OPEN = 16'hAAAA;
   localparam logic [WORD_W-1:0] KEY_KICK_FIRE = 16'h5555;

   localparam int unsigned EN_HI_BIT = 15;
   localparam int unsigned EN_LO_BIT = 14;

   typedef enum logic [1:0] {
      KS_IDLE   = 2'd0,
      KS_CFG_A  = 2'd1,
      KS_CFG_B  = 2'd2,
      KS_KICK_A = 2'd3
   } key_state_e;

   function automatic logic cfg_active(input logic [WORD_W-1:0] w);
      return w[EN_HI_BIT] & w[EN_LO_BIT];
   endfunction

   function automatic key_state_e key_entry(input logic [WORD_W-1:0] w);
      if (w == KEY_CFG_OPEN)       return KS_CFG_A;
      else if (w == KEY_KICK_OPEN) return KS_KICK_A;
      else                         return KS_IDLE;
   endfunction

endpackage

// File: rtl/keyed_watchdog_keyseq.sv
module keyed_watchdog_keyseq
   import keyed_watchdog_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   output logic              cfg_strobe,
   output logic              kick
);

   key_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (wr_en) begin
         unique case (state_q)
            KS_IDLE:   state_d = key_entry(wr_data);
            KS_CFG_A:  state_d = (wr_data == KEY_CFG_ARM) ? KS_CFG_B : key_entry(wr_data);
            KS_CFG_B:  state_d = KS_IDLE;
            KS_KICK_A: state_d = (wr_data == KEY_KICK_FIRE) ? KS_IDLE : key_entry(wr_data);
            default:   state_d = KS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= KS_IDLE;
      else        state_q <= state_d;
   end

   assign cfg_strobe = wr_en && (state_q == KS_CFG_B);
   assign kick       = wr_en && (state_q == KS_KICK_A) && (wr_data == KEY_KICK_FIRE);

   // R1: a keyed load always closes the sequence
   assert_cfg_closes_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_strobe |=> state_q == KS_IDLE);
   // R3: a restart always closes the sequence
   assert_kick_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> state_q == KS_IDLE);
   // R8: without a write the checker holds its state
   assert_no_write_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(state_q));

endmodule

// File: rtl/keyed_watchdog_timebase.sv
module keyed_watchdog_timebase #(
   parameter int unsigned TO_BASE_LOG2 = 23,
   parameter int unsigned SEL_W        = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clear,
   input  logic [SEL_W-1:0] sel,
   output logic             expire
);

   localparam int unsigned CW = TO_BASE_LOG2 + SEL_W + 1;

   logic [CW-1:0]    cnt_q;
   logic [SEL_W-1:0] hit;

   // sel[i] corresponds to timeout bit k = i+1: the period is 2^(BASE+i+1)
   for (genvar i = 0; i < SEL_W; i++) begin : g_term
      assign hit[i] = sel[i] & (&cnt_q[TO_BASE_LOG2+i:0]);
   end

   assign expire = run & (|hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clear)  cnt_q <= '0;
      else if (expire) cnt_q <= '0;
      else if (run)    cnt_q <= cnt_q + CW'(1);
   end

   // R3: clearing forces the count to zero
   assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> cnt_q == '0);
   // R6: a stopped timebase holds its count
   assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clear) |=> $stable(cnt_q));
   // R7: expiry reloads the counter
   assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !clear) |=> cnt_q == '0);

endmodule

// File: rtl/keyed_watchdog_stretch.sv
module keyed_watchdog_stretch #(
   parameter int unsigned PULSE_LEN = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic pulse_o
);

   if (PULSE_LEN == 1) begin : g_single
      logic p_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) p_q <= 1'b0;
         else        p_q <= fire;
      end
      assign pulse_o = p_q;
   end else begin : g_count
      localparam int unsigned PW = $clog2(PULSE_LEN + 1);
      logic [PW-1:0] left_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            left_q <= '0;
         else if (fire)         left_q <= PW'(PULSE_LEN);
         else if (left_q != '0) left_q <= left_q - PW'(1);
      end
      assign pulse_o = (left_q != '0);

      // R7: the remaining length falls by one each cycle
      assert_pulse_countdown_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (pulse_o && !fire) |=> left_q == $past(left_q) - PW'(1));
   end

   // R7: a firing always raises the output in the next cycle
   assert_fire_raises_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> pulse_o);

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
   import keyed_watchdog_pkg::*;
#(
   parameter int unsigned       TO_BASE_LOG2 = 23,
   parameter int unsigned       SEL_W        = 7,
   parameter int unsigned       PULSE_LEN    = 16,
   parameter logic [WORD_W-1:0] RST_CFG      = 16'h0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [WORD_W-1:0] rd_data,
   output logic              wd_rst_o
);

   if (SEL_W < 1 || SEL_W > 13) begin : g_bad_sel
      $error("SEL_W must lie between 1 and 13");
   end
   if (TO_BASE_LOG2 < 1) begin : g_bad_base
      $error("TO_BASE_LOG2 must be at least 1");
   end
   if (PULSE_LEN < 1) begin : g_bad_pulse
      $error("PULSE_LEN must be at least 1");
   end
   if (RST_CFG[EN_HI_BIT] && RST_CFG[EN_LO_BIT]) begin : g_bad_rst
      $error("RST_CFG must leave the watchdog disabled");
   end

   logic              cfg_strobe, kick, cfg_load, clear, run, expire, fire;
   logic [WORD_W-1:0] cfg_q;
   logic [SEL_W-1:0]  sel;

   keyed_watchdog_keyseq u_keyseq (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .cfg_strobe (cfg_strobe),
      .kick       (kick)
   );

   // while active, only a disabling value may be written
   assign cfg_load = cfg_strobe && (!cfg_active(cfg_q) || !cfg_active(wr_data));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cfg_q <= RST_CFG;
      else if (cfg_load) cfg_q <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= RST_CFG;
      else if (rd_en) rd_data <= cfg_q;
   end

   assign sel   = cfg_q[SEL_W:1];
   assign run   = cfg_active(cfg_q) && $onehot(sel);
   assign clear = cfg_load | kick;
   assign fire  = expire & ~clear;

   keyed_watchdog_timebase #(
      .TO_BASE_LOG2 (TO_BASE_LOG2),
      .SEL_W        (SEL_W)
   ) u_timebase (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .clear  (clear),
      .sel    (sel),
      .expire (expire)
   );

   keyed_watchdog_stretch #(
      .PULSE_LEN (PULSE_LEN)
   ) u_stretch (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire    (fire),
      .pulse_o (wd_rst_o)
   );

   // R1: without a write the setting never moves
   assert_cfg_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(cfg_q));
   // R4: an active watchdog can only leave the active state
   assert_no_retune_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_active(cfg_q) && wr_en) |=> ($stable(cfg_q) || !cfg_active(cfg_q)));
   // R6: a disabled, quiet watchdog stays quiet
   assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_active(cfg_q) && !wd_rst_o) |=> !wd_rst_o);
   // R8: rd_data changes only on a read strobe
   assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

endmodule

// File: tb/tb_keyed_watchdog.sv
module tb_keyed_watchdog;

   localparam int unsigned BASE  = 2;
   localparam int unsigned PLEN  = 16;
   localparam int          LIMIT = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [15:0] rd_data;
   logic        wd_rst_o;

   always #5 clk = ~clk;

   keyed_watchdog #(.TO_BASE_LOG2(BASE), .PULSE_LEN(PLEN)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .wd_rst_o(wd_rst_o)
   );

   typedef struct {
      int          cyc;
      bit          is_rd;
      logic [15:0] val;
      string       tag;
   } exp_t;

   exp_t sb[$];
   int   cyc = 0;
   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: compare each expected item in its cycle
   always @(negedge clk) begin
      for (int i = sb.size() - 1; i >= 0; i--) begin
         if (sb[i].cyc <= cyc) begin
            logic [15:0] act;
            act = sb[i].is_rd ? rd_data : {15'd0, wd_rst_o};
            n_chk++;
            if (sb[i].cyc < cyc || act !== sb[i].val) begin
               n_fail++;
               $display("FAIL %s cycle %0d %s actual=%h expected=%h", sb[i].tag, sb[i].cyc,
                        sb[i].is_rd ? "rd_data" : "wd_rst_o", act, sb[i].val);
            end
            sb.delete(i);
         end
      end
   end

   task automatic push(input int c, input bit is_rd, input logic [15:0] v, input string tag);
      exp_t e;
      e.cyc = c; e.is_rd = is_rd; e.val = v; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic exp_rst(input int c, input logic v, input string tag);
      push(c, 1'b0, {15'd0, v}, tag);
   endtask

   task automatic wr(input logic [15:0] d);
      @(negedge clk); wr_en = 1'b1; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd_chk(input logic [15:0] v, input string tag);
      @(negedge clk); rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
      push(cyc + 1, 1'b1, v, tag);
   endtask

   task automatic keyed(input logic [15:0] v);
      wr(16'h3333); wr(16'hCCCC); wr(v);
   endtask

   task automatic wait_until(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (LIMIT) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, LIMIT);
         summary();
      end
   end

   initial begin
      int l, r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9: reset state
      exp_rst(cyc + 1, 1'b0, "R9");
      rd_chk(16'h0000, "R9");

      // R1: a plain write does not load
      wr(16'hC008);
      rd_chk(16'h0000, "R1");

      // R1 R5 R7: keyed load, bit 3 -> 2^(BASE+3) = 32 cycles
      keyed(16'hC008); l = cyc;
      rd_chk(16'hC008, "R1");
      exp_rst(l + 31, 1'b0, "R5");
      exp_rst(l + 32, 1'b1, "R5");
      exp_rst(l + 47, 1'b1, "R7");
      exp_rst(l + 48, 1'b0, "R7");
      exp_rst(l + 63, 1'b0, "R7");
      exp_rst(l + 64, 1'b1, "R7");
      wait_until(l + 66);
      keyed(16'h0000);
      exp_rst(l + 97, 1'b0, "R4");
      wait_until(l + 100);

      // R3: restart moves the expiry and keeps the setting
      keyed(16'hC008); l = cyc;
      repeat (20) @(negedge clk);
      wr(16'hAAAA); wr(16'h5555); r = cyc;
      exp_rst(l + 33, 1'b0, "R3");
      exp_rst(r + 31, 1'b0, "R3");
      exp_rst(r + 32, 1'b1, "R3");
      rd_chk(16'hC008, "R3");
      wait_until(r + 50);
      keyed(16'h0000);

      // R4: retune while active is ignored, disable then load works
      keyed(16'hC008); l = cyc;
      keyed(16'hC010);
      rd_chk(16'hC008, "R4");
      exp_rst(l + 32, 1'b1, "R4");
      wait_until(l + 50);
      keyed(16'h0000);
      rd_chk(16'h0000, "R4");
      keyed(16'hC010); l = cyc;
      rd_chk(16'hC010, "R4");
      exp_rst(l + 63, 1'b0, "R5");
      exp_rst(l + 64, 1'b1, "R5");
      wait_until(l + 82);
      keyed(16'h0000);

      // R2: broken sequence, then re-evaluated start word
      wr(16'h3333); wr(16'h5555); wr(16'hCCCC); wr(16'h4080);
      rd_chk(16'h0000, "R2");
      wr(16'h3333); wr(16'h3333); wr(16'hCCCC); wr(16'h4080);
      rd_chk(16'h4080, "R2");
      keyed(16'hC008); l = cyc;
      repeat (10) @(negedge clk);
      wr(16'h3333); wr(16'hAAAA); wr(16'h5555); r = cyc;
      exp_rst(r + 31, 1'b0, "R2");
      exp_rst(r + 32, 1'b1, "R2");
      wait_until(r + 50);
      keyed(16'h0000);

      // R6: only one enable bit set -> no counting
      keyed(16'h8008); l = cyc;
      rd_chk(16'h8008, "R6");
      exp_rst(l + 33, 1'b0, "R6");
      exp_rst(l + 70, 1'b0, "R6");
      wait_until(l + 72);
      // R5: field not one-hot -> no counting
      keyed(16'hC00C); l = cyc;
      exp_rst(l + 33, 1'b0, "R5");
      exp_rst(l + 65, 1'b0, "R5");
      wait_until(l + 67);
      keyed(16'h0000);

      // R5: top field bit 7 -> 2^(BASE+7) = 512 cycles
      keyed(16'hC080); l = cyc;
      exp_rst(l + 511, 1'b0, "R5");
      exp_rst(l + 512, 1'b1, "R5");
      wait_until(l + 520);
      keyed(16'h0000);

      // R8: reads between key words do not disturb the sequence
      wr(16'h3333);
      rd_chk(16'h0000, "R8");
      wr(16'hCCCC);
      rd_chk(16'h0000, "R8");
      wr(16'h8010);
      rd_chk(16'h8010, "R8");

      wait_until(cyc + 40);
      if (sb.size() != 0) begin
         n_chk++; n_fail++;
         $display("FAIL pending expectations actual=%0d expected=0", sb.size());
      end
      done = 1'b1;
      summary();
   end

endmodule